// File: doc/BRIEF.md
# Illegal Address Interrupt Detector

This block watches the transaction requests of several bus initiators and decides, for every valid request, whether the address is allowed. Two banks of decode windows are checked. The first bank holds the normal windows, which mark the address space that may be used. The second bank holds the error windows, which mark regions that must never be used. Each window has a base address, a power-of-two size and an enable bit.

An address is illegal when it misses every enabled normal window. It is also illegal when it lands in any enabled error window, even if a normal window also covers it. An illegal request sets that initiator's interrupt, and the interrupt stays set until software pulses the initiator's clear input. The block records the address of the first faulting request after each clear. One general interrupt is the OR of all the per-initiator interrupts, so an interrupt controller can take a single line and then read the per-initiator lines.

Routing, arbitration and the bus handshake are outside this block. It only observes the request valid and the address.

Top module: `illegal_addr_irq`

## Requirements
- R1: Window k covers address `a` when `base_k <= a < base_k + 2**lg_k`. Here `lg_k` is the window's size exponent, and `base_k + 2**lg_k` is computed one bit wider than the address, so it does not wrap. Window k's base sits in bits `[k*AW +: AW]` of its base bus, and its exponent sits in bits `[k*LW +: LW]` of its size bus (LW = clog2(AW+1)).
- R2: A valid request whose address is covered by no enabled normal window is illegal.
- R3: A valid request whose address is covered by any enabled error window is illegal, even when an enabled normal window also covers it.
- R4: A window whose enable bit is 0 takes no part in the check, in either bank.
- R5: An illegal valid request from initiator i sets `irq_init[i]` on the next clock edge. A legal request never sets it.
- R6: `irq_init[i]` stays set until a cycle in which `clr[i]` is high. When that cycle also carries an illegal valid request from initiator i, the bit stays set. Otherwise it reads 0 after that edge.
- R7: `fault_addr[i]` takes the address of an illegal request when `irq_init[i]` is clear or `clr[i]` is high in the same cycle. Later illegal requests leave it unchanged. Clearing does not erase it.
- R8: While `req_valid[i]` is low, the address on `req_addr[i]` has no effect on the interrupt or on the captured address of initiator i.
- R9: `irq_any` is high exactly when at least one bit of `irq_init` is high, in the same cycle.
- R10: The requests and clears of one initiator never change the interrupt or captured address of another.
- R11: After reset, every interrupt output is 0 and every captured address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | N_INIT | Request valid, one bit per initiator |
| req_addr | input | N_INIT*AW | Request address, initiator i in `[i*AW +: AW]` |
| clr | input | N_INIT | Interrupt clear strobe, one bit per initiator |
| norm_base | input | N_NORM*AW | Normal window base addresses |
| norm_lg | input | N_NORM*LW | Normal window size exponents |
| norm_en | input | N_NORM | Normal window enables |
| err_base | input | N_ERR*AW | Error window base addresses |
| err_lg | input | N_ERR*LW | Error window size exponents |
| err_en | input | N_ERR | Error window enables |
| irq_init | output | N_INIT | Sticky interrupt, one bit per initiator |
| irq_any | output | 1 | OR of all per-initiator interrupts |
| fault_addr | output | N_INIT*AW | Captured faulting address per initiator |

## Verification
The assertions check these behaviours on every cycle:
- A set interrupt stays set until its clear.
- The captured address holds while the interrupt stays set.
- A cycle without a request never raises an interrupt.
- A lone clear drops the interrupt.
- The general line always follows the OR of the per-initiator lines.

The assertions cannot see whether an address is legal. Only the bench's sweeps can show that. The bench runs every address against window sets with overlaps, disabled windows, an error window inside a normal window and a window that runs past the top of the address space. The bench also shows the capture-ordering cases, such as a second fault and a clear arriving together with a new fault.

// File: rtl/illegal_addr_pkg.sv
// Shared helpers for the illegal address detector.
// Assumes: address widths are small enough that clog2(AW+1) fits an int.
package illegal_addr_pkg;

    // Width of a size-exponent field able to express 0..AW.
    function automatic int lg_width(input int aw);
        return $clog2(aw + 1);
    endfunction

endpackage

// File: rtl/addr_window_match.sv
// One decode window: reports whether an address lies in [base, base+2**lg).
// Assumes: lg <= AW. The end bound is formed one bit wider, so windows that
// reach the top of the address space do not wrap.
module addr_window_match #(
    parameter int AW = 16,
    parameter int LW = illegal_addr_pkg::lg_width(AW)
) (
    input  logic [AW-1:0] base,
    input  logic [LW-1:0] lg,
    input  logic          en,
    input  logic [AW-1:0] addr,
    output logic          hit
);
    localparam int EW = AW + 1;

    logic [EW-1:0] span;
    logic [EW-1:0] limit;

    // Compute the exclusive upper bound and compare both ends.
    always_comb begin
        span  = EW'(1) << lg;
        limit = {1'b0, base} + span;
        hit   = en && (addr >= base) && ({1'b0, addr} < limit);
    end

endmodule

// File: rtl/addr_legality_check.sv
// Checks one address against every normal window and every error window.
// Assumes: window configuration is stable while requests are checked.
module addr_legality_check #(
    parameter int AW     = 16,
    parameter int N_NORM = 4,
    parameter int N_ERR  = 2,
    parameter int LW     = illegal_addr_pkg::lg_width(AW)
) (
    input  logic [AW-1:0]        addr,
    input  logic [N_NORM*AW-1:0] norm_base,
    input  logic [N_NORM*LW-1:0] norm_lg,
    input  logic [N_NORM-1:0]    norm_en,
    input  logic [N_ERR*AW-1:0]  err_base,
    input  logic [N_ERR*LW-1:0]  err_lg,
    input  logic [N_ERR-1:0]     err_en,
    output logic                 illegal
);
    logic [N_NORM-1:0] norm_hit;
    logic [N_ERR-1:0]  err_hit;

    for (genvar k = 0; k < N_NORM; k++) begin : g_norm
        addr_window_match #(.AW(AW), .LW(LW)) u_win (
            .base (norm_base[k*AW +: AW]),
            .lg   (norm_lg[k*LW +: LW]),
            .en   (norm_en[k]),
            .addr (addr),
            .hit  (norm_hit[k])
        );
    end

    for (genvar k = 0; k < N_ERR; k++) begin : g_err
        addr_window_match #(.AW(AW), .LW(LW)) u_win (
            .base (err_base[k*AW +: AW]),
            .lg   (err_lg[k*LW +: LW]),
            .en   (err_en[k]),
            .addr (addr),
            .hit  (err_hit[k])
        );
    end

    // Illegal when no normal window covers the address or an error window does.
    always_comb illegal = !(|norm_hit) || (|err_hit);

endmodule

// File: rtl/irq_capture.sv
// Sticky interrupt and first-fault address register for one initiator.
// Assumes: illegal is valid whenever req_valid is high. A new fault wins over
// a clear in the same cycle.
module irq_capture #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          illegal,
    input  logic [AW-1:0] addr,
    input  logic          clr,
    output logic          irq,
    output logic [AW-1:0] fault_addr
);
    logic fault;

    // A fault is only seen on a valid request.
    always_comb fault = req_valid && illegal;

    // Set on fault, drop on clear, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      irq <= 1'b0;
        else if (fault)  irq <= 1'b1;
        else if (clr)    irq <= 1'b0;
    end

    // Record the address of the first fault after reset or a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                    fault_addr <= '0;
        else if (fault && (!irq || clr)) fault_addr <= addr;
    end

endmodule

// File: rtl/illegal_addr_irq.sv
// Top: one legality check and one interrupt register per initiator, plus the
// general interrupt. Assumes: the window buses are shared by all initiators.
module illegal_addr_irq #(
    parameter int N_INIT = 4,
    parameter int N_NORM = 4,
    parameter int N_ERR  = 2,
    parameter int AW     = 16,
    parameter int LW     = illegal_addr_pkg::lg_width(AW)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_INIT-1:0]    req_valid,
    input  logic [N_INIT*AW-1:0] req_addr,
    input  logic [N_INIT-1:0]    clr,
    input  logic [N_NORM*AW-1:0] norm_base,
    input  logic [N_NORM*LW-1:0] norm_lg,
    input  logic [N_NORM-1:0]    norm_en,
    input  logic [N_ERR*AW-1:0]  err_base,
    input  logic [N_ERR*LW-1:0]  err_lg,
    input  logic [N_ERR-1:0]     err_en,
    output logic [N_INIT-1:0]    irq_init,
    output logic                 irq_any,
    output logic [N_INIT*AW-1:0] fault_addr
);
    logic [N_INIT-1:0] illegal;

    for (genvar i = 0; i < N_INIT; i++) begin : g_init
        addr_legality_check #(
            .AW(AW), .N_NORM(N_NORM), .N_ERR(N_ERR), .LW(LW)
        ) u_chk (
            .addr      (req_addr[i*AW +: AW]),
            .norm_base (norm_base),
            .norm_lg   (norm_lg),
            .norm_en   (norm_en),
            .err_base  (err_base),
            .err_lg    (err_lg),
            .err_en    (err_en),
            .illegal   (illegal[i])
        );

        irq_capture #(.AW(AW)) u_cap (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_valid  (req_valid[i]),
            .illegal    (illegal[i]),
            .addr       (req_addr[i*AW +: AW]),
            .clr        (clr[i]),
            .irq        (irq_init[i]),
            .fault_addr (fault_addr[i*AW +: AW])
        );
    end

    // General interrupt combines all per-initiator lines.
    always_comb irq_any = |irq_init;

endmodule

// File: rtl/illegal_addr_irq_chk.sv
// Cycle-level properties of the detector, attached by bind.
// Assumes: the same parameters as the top it is bound to.
module illegal_addr_irq_chk #(
    parameter int N_INIT = 4,
    parameter int AW     = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_INIT-1:0]    req_valid,
    input logic [N_INIT-1:0]    clr,
    input logic [N_INIT-1:0]    irq_init,
    input logic                 irq_any,
    input logic [N_INIT*AW-1:0] fault_addr
);
    for (genvar i = 0; i < N_INIT; i++) begin : g_p
        // R6
        irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_init[i] && !clr[i] |=> irq_init[i]);
        // R6
        irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr[i] && !req_valid[i] |=> !irq_init[i]);
        // R7
        fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_init[i] && !clr[i] |=> $stable(fault_addr[i*AW +: AW]));
        // R8
        idle_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid[i] && !irq_init[i] |=> !irq_init[i]);
        // R7
        idle_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid[i] |=> $stable(fault_addr[i*AW +: AW]));
    end

    // R9
    general_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any == ($countones(irq_init) != 0));

endmodule

bind illegal_addr_irq illegal_addr_irq_chk #(.N_INIT(N_INIT), .AW(AW)) u_props (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .clr        (clr),
    .irq_init   (irq_init),
    .irq_any    (irq_any),
    .fault_addr (fault_addr)
);

// File: tb/test_illegal_addr_irq.sv
module test_illegal_addr_irq;
    localparam int NI = 2, NN = 2, NE = 1, AW = 8, LW = 4;

    logic              clk = 0;
    logic              rst_n = 0;
    logic [NI-1:0]     req_valid = '0;
    logic [NI*AW-1:0]  req_addr = '0;
    logic [NI-1:0]     clr = '0;
    logic [NN*AW-1:0]  norm_base = '0;
    logic [NN*LW-1:0]  norm_lg = '0;
    logic [NN-1:0]     norm_en = '0;
    logic [NE*AW-1:0]  err_base = '0;
    logic [NE*LW-1:0]  err_lg = '0;
    logic [NE-1:0]     err_en = '0;
    logic [NI-1:0]     irq_init;
    logic              irq_any;
    logic [NI*AW-1:0]  fault_addr;

    int checks = 0, errors = 0;
    int nb[NN], nl[NN], ne[NN];
    int eb, el, ee;
    bit done = 0;

    always #10 clk = ~clk; // 50 MHz

    illegal_addr_irq #(.N_INIT(NI), .N_NORM(NN), .N_ERR(NE), .AW(AW), .LW(LW))
    i_illegal_addr_irq (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    function automatic bit covers(input int a, input int b, input int lg);
        return a >= b && a < b + (1 << lg);
    endfunction

    function automatic bit exp_illegal(input int a);
        bit any = 0;
        for (int k = 0; k < NN; k++) if (ne[k] != 0 && covers(a, nb[k], nl[k])) any = 1;
        return !any || (ee != 0 && covers(a, eb, el));
    endfunction

    task automatic apply_cfg();
        for (int k = 0; k < NN; k++) begin
            norm_base[k*AW +: AW] = AW'(nb[k]);
            norm_lg[k*LW +: LW]   = LW'(nl[k]);
            norm_en[k]            = ne[k] != 0;
        end
        err_base = AW'(eb); err_lg = LW'(el); err_en = ee != 0;
    endtask

    // Present one request, sample the result, then clear.
    task automatic probe(input int ini, input int a, input string req);
        bit e = exp_illegal(a);
        req_valid[ini] = 1; req_addr[ini*AW +: AW] = AW'(a);
        @(negedge clk);
        req_valid[ini] = 0;
        check(irq_init[ini] == e, req, int'(irq_init[ini]), int'(e));
        check(irq_any == e, {req, "/R9"}, int'(irq_any), int'(e));
        if (e) check(fault_addr[ini*AW +: AW] == AW'(a), {req, "/R7"},
                     int'(fault_addr[ini*AW +: AW]), a);
        clr[ini] = 1;
        @(negedge clk);
        clr[ini] = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R11 reset state
        check(irq_init == '0 && !irq_any, "R11", int'(irq_init), 0);
        check(fault_addr == '0, "R11", int'(fault_addr), 0);

        // Config A: two normal windows, an error window inside the second.
        nb = '{8'h20, 8'h80}; nl = '{4, 6}; ne = '{1, 1};
        eb = 8'h90; el = 3; ee = 1;
        apply_cfg();
        @(negedge clk);
        for (int a = 0; a < 256; a++) probe(0, a, "R1/R2/R3/R5");
        // R10: initiator 1 untouched by the sweep of initiator 0
        check(irq_init[1] == 0 && fault_addr[AW +: AW] == '0, "R10",
              int'(fault_addr[AW +: AW]), 0);
        for (int a = 0; a < 256; a += 7) probe(1, a, "R5/R10");

        // Config B: second normal and error windows disabled, first reaches top.
        nb = '{8'hF0, 8'h00}; nl = '{5, 8}; ne = '{1, 0};
        eb = 8'h00; el = 8; ee = 0;
        apply_cfg();
        @(negedge clk);
        for (int a = 0; a < 256; a++) probe(0, a, "R4/R1");

        // R8: illegal address without valid has no effect
        req_addr[0 +: AW] = 8'h10;
        repeat (2) @(negedge clk);
        check(irq_init[0] == 0, "R8", int'(irq_init[0]), 0);
        check(fault_addr[0 +: AW] == 8'hEF, "R8", int'(fault_addr[0 +: AW]), 8'hEF);

        // R7: first fault captured, second ignored
        req_valid[0] = 1; req_addr[0 +: AW] = 8'h11;
        @(negedge clk);
        req_addr[0 +: AW] = 8'h22;
        @(negedge clk);
        req_valid[0] = 0;
        check(irq_init[0] == 1, "R6", int'(irq_init[0]), 1);
        check(fault_addr[0 +: AW] == 8'h11, "R7", int'(fault_addr[0 +: AW]), 8'h11);
        // R6/R7: clear with a new fault keeps irq and captures the new address
        req_valid[0] = 1; clr[0] = 1; req_addr[0 +: AW] = 8'h33;
        @(negedge clk);
        req_valid[0] = 0; clr[0] = 0;
        check(irq_init[0] == 1, "R6", int'(irq_init[0]), 1);
        check(fault_addr[0 +: AW] == 8'h33, "R7", int'(fault_addr[0 +: AW]), 8'h33);
        // R6: lone clear drops irq, captured address kept
        clr[0] = 1;
        @(negedge clk);
        clr[0] = 0;
        check(irq_init[0] == 0 && !irq_any, "R6", int'(irq_init[0]), 0);
        check(fault_addr[0 +: AW] == 8'h33, "R7", int'(fault_addr[0 +: AW]), 8'h33);
        // R9/R10: both initiators faulting, clear one
        req_valid = 2'b11; req_addr = {8'h44, 8'h55};
        @(negedge clk);
        req_valid = '0; clr = 2'b01;
        @(negedge clk);
        clr = '0;
        check(irq_init == 2'b10 && irq_any, "R9/R10", int'(irq_init), 2);
        check(fault_addr[AW +: AW] == 8'h44, "R10", int'(fault_addr[AW +: AW]), 8'h44);
        finish_run();
    end
endmodule